// File: doc/BRIEF.md
# Single-Block Bus-Mastering DMA Engine

This block copies one block of words between an I/O device and memory without involving the processor for each word. Software writes a start address, a word count and a control word, and sets the go bit. The engine then waits for the device to ask for a word. It asks the processor for the bus and puts nothing on the bus until the processor grants it. While it holds the grant, the engine drives the address and the read or write strobe itself and acknowledges the device for each word it moves.

The engine gives the bus back as soon as the device stops asking, and asks for it again when the device asks again. After the last word it releases the bus, sets a done flag and can raise an interrupt. Every new block needs a fresh count and a fresh go write. A stop bit ends a running transfer early.

Top module: `dma_block_mover`

## Requirements
- R1: After reset, bus_req, bus_rd, bus_wr, dev_ack, busy, done and irq are all low.
- R2: bus_rd, bus_wr and a nonzero bus_addr appear only while bus_grant is high. When the engine does not own the bus, bus_addr and bus_wdata are zero.
- R3: Control bit 1 selects the direction. With 0, each word goes from the device to memory: bus_wr is high and bus_wdata equals dev_wdata. With 1, each word goes from memory to the device: bus_rd is high and dev_rdata equals bus_rdata.
- R4: A word moves in each cycle in which the engine holds the grant and dev_req is high. In that cycle dev_ack is high. The first word uses the programmed address, and each later word uses the previous address plus one.
- R5: Exactly as many words move as the programmed count. In the cycle after the last word, bus_req and busy are low and done is high. irq equals done AND control bit 3.
- R6: If dev_req is low while the engine owns the bus, bus_req falls in the next cycle. bus_req rises again in the cycle after dev_req returns.
- R7: While busy, writes to the address (select 0), count (select 1) and control (select 2) registers have no effect. The exception is control bit 2 (stop): in the next cycle busy and bus_req are low, done stays low, and no further words move.
- R8: A go write (control bit 0) is ignored when the count is zero, so a finished block does not restart until the count is written again. An accepted go write clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe from the processor |
| cfg_sel | input | 2 | Register select: 0 address, 1 count, 2 control |
| cfg_wdata | input | DW | Register write data |
| busy | output | 1 | A block is in progress |
| done | output | 1 | The last block finished |
| irq | output | 1 | Completion interrupt |
| dev_req | input | 1 | Device wants a word moved |
| dev_ack | output | 1 | A word is moved this cycle |
| dev_wdata | input | DW | Word from the device |
| dev_rdata | output | DW | Word to the device |
| bus_req | output | 1 | Request for bus ownership |
| bus_grant | input | 1 | Processor has released the bus |
| bus_own | output | 1 | The engine drives the bus this cycle |
| bus_addr | output | AW | Memory address |
| bus_rd | output | 1 | Memory read strobe |
| bus_wr | output | 1 | Memory write strobe |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data |

## Verification
The assertions check three things on every cycle: the bus is released right after the last word, after a stop and after the device goes quiet; done rises only when the count has run out; and address writes made while busy leave the address alone. Only the bench scenarios can show the data itself: that each word lands at the right address in the right direction, that the number of acknowledges matches the count, and that a stale go write or an ignored direction change leaves memory exactly as expected.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PARK = 2'd1,
    ST_ASK  = 2'd2,
    ST_MOVE = 2'd3
  } seq_state_t;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_GO   = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_STOP = 2;
  localparam int CTL_IRQ  = 3;
endpackage

// File: rtl/dma_blk_regs.sv
module dma_blk_regs
  import dma_blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          word_done,
  input  logic          finish,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] remaining,
  output logic          dir,
  output logic          irq_en,
  output logic          done,
  output logic          start,
  output logic          stop
);
  logic [AW-1:0] addr_n;
  logic [CW-1:0] cnt_n;
  logic          dir_n, ie_n, done_n;
  logic          wr_idle;

  assign wr_idle = cfg_we && !busy;
  assign start   = wr_idle && (cfg_sel == SEL_CTRL) && cfg_wdata[CTL_GO]
                   && (remaining != '0);
  assign stop    = cfg_we && busy && (cfg_sel == SEL_CTRL) && cfg_wdata[CTL_STOP];

  always_comb begin
    addr_n = cur_addr;
    cnt_n  = remaining;
    dir_n  = dir;
    ie_n   = irq_en;
    done_n = done;
    if (wr_idle && cfg_sel == SEL_ADDR)       addr_n = cfg_wdata[AW-1:0];
    else if (word_done)                       addr_n = cur_addr + 1'b1;
    if (wr_idle && cfg_sel == SEL_COUNT)      cnt_n  = cfg_wdata[CW-1:0];
    else if (word_done)                       cnt_n  = remaining - 1'b1;
    if (wr_idle && cfg_sel == SEL_CTRL) begin
      dir_n = cfg_wdata[CTL_DIR];
      ie_n  = cfg_wdata[CTL_IRQ];
    end
    if (start)       done_n = 1'b0;
    else if (finish) done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr  <= '0;
      remaining <= '0;
      dir       <= 1'b0;
      irq_en    <= 1'b0;
      done      <= 1'b0;
    end else begin
      cur_addr  <= addr_n;
      remaining <= cnt_n;
      dir       <= dir_n;
      irq_en    <= ie_n;
      done      <= done_n;
    end
  end

  p_done_at_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (remaining == '0))
    else $error("done rose with words left");

  p_busy_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_we && !word_done) |=> $stable(cur_addr))
    else $error("address changed by a write while busy");
endmodule

// File: rtl/dma_blk_seq.sv
module dma_blk_seq
  import dma_blk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic dir,
  input  logic last,
  input  logic dev_req,
  input  logic bus_grant,
  output logic busy,
  output logic bus_req,
  output logic own,
  output logic word_done,
  output logic finish,
  output logic rd,
  output logic wr
);
  seq_state_t state, state_n;

  assign busy      = (state != ST_IDLE);
  assign bus_req   = (state == ST_ASK) || (state == ST_MOVE);
  assign own       = (state == ST_MOVE) && bus_grant;
  assign word_done = own && dev_req && !stop;
  assign finish    = word_done && last;
  assign rd        = word_done && dir;
  assign wr        = word_done && !dir;

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (start) state_n = ST_PARK;
      ST_PARK: if (stop) state_n = ST_IDLE;
               else if (dev_req) state_n = ST_ASK;
      ST_ASK:  if (stop) state_n = ST_IDLE;
               else if (bus_grant) state_n = ST_MOVE;
      ST_MOVE: if (stop) state_n = ST_IDLE;
               else if (finish) state_n = ST_IDLE;
               else if (!dev_req) state_n = ST_PARK;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  p_release_on_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!bus_req && !busy))
    else $error("bus held after last word");

  p_release_on_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own && !dev_req) |=> !bus_req)
    else $error("bus held while device idle");

  p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !bus_req))
    else $error("stop did not end transfer");
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_blk_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic          busy,
  output logic          done,
  output logic          irq,
  input  logic          dev_req,
  output logic          dev_ack,
  input  logic [DW-1:0] dev_wdata,
  output logic [DW-1:0] dev_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic          bus_own,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);
  logic [1:0]    rst_sync;
  logic          rst_q_n;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] remaining;
  logic          dir, irq_en, start, stop, word_done, finish, own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  dma_blk_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_q_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .word_done(word_done),
    .finish(finish), .cur_addr(cur_addr), .remaining(remaining),
    .dir(dir), .irq_en(irq_en), .done(done), .start(start), .stop(stop)
  );

  dma_blk_seq u_seq (
    .clk(clk), .rst_n(rst_q_n), .start(start), .stop(stop), .dir(dir),
    .last(remaining == CW'(1)), .dev_req(dev_req), .bus_grant(bus_grant),
    .busy(busy), .bus_req(bus_req), .own(own), .word_done(word_done),
    .finish(finish), .rd(bus_rd), .wr(bus_wr)
  );

  assign bus_own   = own;
  assign bus_addr  = own ? cur_addr : '0;
  assign bus_wdata = (own && !dir) ? dev_wdata : '0;
  assign dev_rdata = bus_rd ? bus_rdata : '0;
  assign dev_ack   = word_done;
  assign irq       = done && irq_en;
endmodule

// File: tb/dma_block_mover_test.sv
module dma_block_mover_test;
  typedef struct packed {
    logic [15:0] addr;
    logic [15:0] cnt;
    logic        dir;
    logic        ie;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{addr: 16'd4,  cnt: 16'd3, dir: 1'b0, ie: 1'b1},
    '{addr: 16'd20, cnt: 16'd5, dir: 1'b1, ie: 1'b0},
    '{addr: 16'd40, cnt: 16'd1, dir: 1'b0, ie: 1'b0},
    '{addr: 16'd50, cnt: 16'd6, dir: 1'b1, ie: 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [15:0] cfg_wdata;
  logic        busy, done, irq, dev_req, dev_ack, bus_req, bus_grant, bus_own;
  logic        bus_rd, bus_wr;
  logic [15:0] dev_wdata, dev_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [15:0] mem [64];
  logic [15:0] rx  [256];
  int          ack_cnt, r2_bad, n_chk, n_bad;

  always #10 clk = ~clk;

  dma_block_mover uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .irq(irq),
    .dev_req(dev_req), .dev_ack(dev_ack), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .bus_req(bus_req), .bus_grant(bus_grant),
    .bus_own(bus_own), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  assign dev_wdata = 16'h5000 + ack_cnt[15:0];
  assign bus_rdata = mem[bus_addr[5:0]];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bus_grant <= 1'b0;
    else        bus_grant <= bus_req;

  always @(posedge clk) begin
    if (bus_wr) mem[bus_addr[5:0]] <= bus_wdata;
    if (dev_ack) begin
      rx[ack_cnt[7:0]] <= dev_rdata;
      ack_cnt <= ack_cnt + 1;
    end
  end

  always @(negedge clk)
    if (rst_n && (bus_rd || bus_wr || bus_addr != 16'd0) && !bus_grant)
      r2_bad <= r2_bad + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int base;
    n_chk = 0; n_bad = 0; ack_cnt = 0; r2_bad = 0;
    for (int i = 0; i < 64; i++) mem[i] = 16'(i * 3 + 1);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = '0; dev_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 strobes", bus_rd | bus_wr, 0);
    chk("R1 dev_ack", dev_ack, 0);
    chk("R1 busy/done/irq", {busy, done, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // vector table: R3 R4 R5
    for (int v = 0; v < 4; v++) begin
      base = ack_cnt;
      cfg(2'd0, VECS[v].addr);
      cfg(2'd1, VECS[v].cnt);
      dev_req = 1'b1;
      cfg(2'd2, {12'd0, VECS[v].ie, 1'b0, VECS[v].dir, 1'b1});
      wait_idle();
      dev_req = 1'b0;
      chk("R5 word count", ack_cnt - base, int'(VECS[v].cnt));
      chk("R5 done", done, 1);
      chk("R5 irq", irq, int'(VECS[v].ie));
      chk("R5 bus_req released", bus_req, 0);
      for (int w = 0; w < int'(VECS[v].cnt); w++) begin
        if (VECS[v].dir)
          chk("R3 mem to device", rx[8'(base + w)], (int'(VECS[v].addr) + w) * 3 + 1);
        else
          chk("R4 device to mem", mem[int'(VECS[v].addr) + w], 16'h5000 + base + w);
      end
    end

    // R6 release and re-request
    base = ack_cnt;
    cfg(2'd0, 16'd30);
    cfg(2'd1, 16'd4);
    dev_req = 1'b1;
    cfg(2'd2, 16'h0001);
    for (int i = 0; i < 50 && !dev_ack; i++) @(negedge clk);
    dev_req = 1'b0;
    @(negedge clk);
    chk("R6 bus_req drop", bus_req, 0);
    chk("R6 still busy", busy, 1);
    @(negedge clk);
    dev_req = 1'b1;
    @(negedge clk);
    chk("R6 bus_req again", bus_req, 1);
    wait_idle();
    dev_req = 1'b0;
    chk("R6 words", ack_cnt - base, 4);
    for (int w = 0; w < 4; w++)
      chk("R4 address step", mem[30 + w], 16'h5000 + base + w);

    // R7 writes while busy ignored
    base = ack_cnt;
    cfg(2'd0, 16'd10);
    cfg(2'd1, 16'd2);
    cfg(2'd2, 16'h0001);
    cfg(2'd0, 16'd44);
    cfg(2'd1, 16'd9);
    cfg(2'd2, 16'h0003);
    chk("R7 busy", busy, 1);
    dev_req = 1'b1;
    wait_idle();
    dev_req = 1'b0;
    chk("R7 count kept", ack_cnt - base, 2);
    chk("R7 addr/dir kept", mem[10], 16'h5000 + base);
    chk("R7 addr/dir kept", mem[11], 16'h5000 + base + 1);
    chk("R7 no write at 44", mem[44], 44 * 3 + 1);

    // R8 go with zero count ignored; done cleared on start
    base = ack_cnt;
    dev_req = 1'b1;
    cfg(2'd2, 16'h0001);
    chk("R8 zero count no start", busy, 0);
    repeat (4) @(negedge clk);
    chk("R8 no words", ack_cnt - base, 0);
    chk("R8 done kept", done, 1);
    dev_req = 1'b0;
    cfg(2'd1, 16'd1);
    cfg(2'd0, 16'd45);
    cfg(2'd2, 16'h0001);
    chk("R8 done cleared", done, 0);
    chk("R8 started", busy, 1);
    dev_req = 1'b1;
    wait_idle();
    dev_req = 1'b0;
    chk("R8 finished", done, 1);

    // R7 stop bit
    base = ack_cnt;
    cfg(2'd0, 16'd58);
    cfg(2'd1, 16'd5);
    dev_req = 1'b1;
    cfg(2'd2, 16'h0003);
    for (int i = 0; i < 50 && (ack_cnt - base) < 2; i++) @(negedge clk);
    cfg(2'd2, 16'h0004);
    chk("R7 stop busy", busy, 0);
    chk("R7 stop bus_req", bus_req, 0);
    chk("R7 stop done", done, 0);
    base = ack_cnt;
    repeat (5) @(negedge clk);
    chk("R7 no words after stop", ack_cnt - base, 0);
    dev_req = 1'b0;

    chk("R2 bus quiet without grant", r2_bad, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule